// File: doc/BRIEF.md
# Self-Synchronizing Bit Scrambler and Descrambler

This block whitens a serial transmit bit stream and restores a serial receive bit stream with the seven-stage polynomial 1 + z^-4 + z^-7. Both directions move one bit per enable strobe. Each output bit is combinational from the input bit and the current register. The register advances at the clock edge where the enable is high.

On transmit the register holds the last seven scrambled output bits. At each frame start it is loaded with one of two programmable seeds, picked by the preamble format input. Every bit of the frame is scrambled the same way, whether it is sync, header or payload. On receive the register holds the last seven received line bits. It needs no seed and produces correct data once seven bits have arrived. A bypass input makes both directions pass data through unchanged.

Top module: `selfSyncScrambler`

## Requirements
- R1: Synchronous reset (rstN low at a clock edge) sets the long seed to 7'b1101100 and the short seed to 7'b0011011. It loads the transmit register with the default seed chosen by txShortFmt during reset, and clears the receive register to zero.
- R2: With bypass low and txEn high, txOut = txBit XOR T[3] XOR T[6]. T[k] is the scrambled output bit from k+1 enabled bits earlier, and T[0] is the most recent. At the edge the register shifts and txOut enters T[0].
- R3: txStart loads the seed selected by txShortFmt into the transmit register (0 selects the long seed, 1 the short seed). A bit enabled in the same cycle is scrambled with that seed as the register contents. Seed bit k stands for the stage at delay k+1.
- R4: longSeedWe writes seedData into the long seed and shortSeedWe writes it into the short seed. Each write leaves the other seed unchanged. A write takes effect for frame starts in later cycles.
- R5: While bypass is high, txOut equals txBit and rxOut equals rxBit. The registers keep advancing with the line bit: txBit on transmit, rxBit on receive.
- R6: In a cycle without txEn the transmit register holds, and in a cycle without rxEn the receive register holds, whatever the data inputs do.
- R7: With bypass low and rxEn high, rxOut = rxBit XOR R[3] XOR R[6], where R holds the last seven received bits. Fed with a scrambler's output, the descrambler returns the original data from the eighth bit on, whatever its starting state.
- R8: An all-zero transmit register with zero input produces zeros and stays zero. An all-ones register with one input produces ones. A single differing input bit breaks the lock, and a later bit of the same repeated input comes out changed within seven bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| bypass | input | 1 | Pass data through unchanged in both directions |
| txShortFmt | input | 1 | Preamble format: 1 short, 0 long |
| txStart | input | 1 | Frame start; loads the selected seed |
| txEn | input | 1 | Transmit bit strobe |
| txBit | input | 1 | Transmit data bit |
| txOut | output | 1 | Scrambled transmit bit |
| rxEn | input | 1 | Receive bit strobe |
| rxBit | input | 1 | Received line bit |
| rxOut | output | 1 | Descrambled receive bit |
| longSeedWe | input | 1 | Write strobe for the long seed |
| shortSeedWe | input | 1 | Write strobe for the short seed |
| seedData | input | 7 | Seed value to write |

## Verification
The assertions assume that the inputs are stable around each rising edge. They also assume that the transmit register starts from the seed picked by txShortFmt during reset, so the format has to be steady throughout reset. The bench changes every input only just after the falling edge. It holds txShortFmt constant for each reset. It sets seeds only through the write strobes, so the checker's copies of the seeds and line history match what the block can legally hold.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef struct packed {
    logic seedLoad;
    logic useShort;
    logic txAdv;
    logic rxAdv;
    logic passThru;
    logic wrLong;
    logic wrShort;
  } scrStrobes_t;
endpackage

// File: rtl/scrCtrl.sv
module scrCtrl
  import scr_pkg::*;
(
  input  logic        txStart,
  input  logic        txShortFmt,
  input  logic        txEn,
  input  logic        rxEn,
  input  logic        bypass,
  input  logic        longSeedWe,
  input  logic        shortSeedWe,
  output scrStrobes_t strb
);
  always_comb begin
    strb.seedLoad = txStart;
    strb.useShort = txShortFmt;
    strb.txAdv    = txEn;
    strb.rxAdv    = rxEn;
    strb.passThru = bypass;
    strb.wrLong   = longSeedWe;
    strb.wrShort  = shortSeedWe;
  end
endmodule

// File: rtl/scrLane.sv
module scrLane #(
  parameter int WIDTH        = 7,
  parameter int TAP_A        = 4,
  parameter int TAP_B        = 7,
  parameter bit FEED_FORWARD = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rstVal,
  input  logic             load,
  input  logic [WIDTH-1:0] loadVal,
  input  logic             adv,
  input  logic             bypass,
  input  logic             din,
  output logic             dout
);
  logic [WIDTH-1:0] shReg;
  logic [WIDTH-1:0] curState;
  logic             fbBit;
  logic             shiftIn;

  assign curState = load ? loadVal : shReg;
  assign fbBit    = curState[TAP_A-1] ^ curState[TAP_B-1];
  assign dout     = bypass ? din : (din ^ fbBit);

  generate
    if (FEED_FORWARD) begin : g_ff
      assign shiftIn = din;
    end else begin : g_fb
      assign shiftIn = dout;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)
      shReg <= rstVal;
    else if (adv)
      shReg <= {curState[WIDTH-2:0], shiftIn};
    else
      shReg <= curState;
  end
endmodule

// File: rtl/scrDatapath.sv
module scrDatapath
  import scr_pkg::*;
#(
  parameter int               WIDTH      = 7,
  parameter int               TAP_A      = 4,
  parameter int               TAP_B      = 7,
  parameter logic [WIDTH-1:0] LONG_DEF   = 7'b1101100,
  parameter logic [WIDTH-1:0] SHORT_DEF  = 7'b0011011
) (
  input  logic             clk,
  input  logic             rstN,
  input  scrStrobes_t      strb,
  input  logic [WIDTH-1:0] seedData,
  input  logic             txBit,
  input  logic             rxBit,
  output logic             txOut,
  output logic             rxOut
);
  localparam logic [WIDTH-1:0] RX_RST = '0;

  logic [WIDTH-1:0] longSeed;
  logic [WIDTH-1:0] shortSeed;
  logic [WIDTH-1:0] seedSel;
  logic [WIDTH-1:0] txRstVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      longSeed  <= LONG_DEF;
      shortSeed <= SHORT_DEF;
    end else begin
      if (strb.wrLong)  longSeed  <= seedData;
      if (strb.wrShort) shortSeed <= seedData;
    end
  end

  assign seedSel  = strb.useShort ? shortSeed : longSeed;
  assign txRstVal = strb.useShort ? SHORT_DEF : LONG_DEF;

  scrLane #(.WIDTH(WIDTH), .TAP_A(TAP_A), .TAP_B(TAP_B), .FEED_FORWARD(1'b0)) u_txLane (
    .clk(clk), .rstN(rstN), .rstVal(txRstVal),
    .load(strb.seedLoad), .loadVal(seedSel),
    .adv(strb.txAdv), .bypass(strb.passThru),
    .din(txBit), .dout(txOut)
  );

  scrLane #(.WIDTH(WIDTH), .TAP_A(TAP_A), .TAP_B(TAP_B), .FEED_FORWARD(1'b1)) u_rxLane (
    .clk(clk), .rstN(rstN), .rstVal(RX_RST),
    .load(1'b0), .loadVal(RX_RST),
    .adv(strb.rxAdv), .bypass(strb.passThru),
    .din(rxBit), .dout(rxOut)
  );
endmodule

// File: rtl/selfSyncScrambler.sv
module selfSyncScrambler
  import scr_pkg::*;
#(
  parameter int               WIDTH     = 7,
  parameter int               TAP_A     = 4,
  parameter int               TAP_B     = 7,
  parameter logic [WIDTH-1:0] LONG_DEF  = 7'b1101100,
  parameter logic [WIDTH-1:0] SHORT_DEF = 7'b0011011
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bypass,
  input  logic             txShortFmt,
  input  logic             txStart,
  input  logic             txEn,
  input  logic             txBit,
  output logic             txOut,
  input  logic             rxEn,
  input  logic             rxBit,
  output logic             rxOut,
  input  logic             longSeedWe,
  input  logic             shortSeedWe,
  input  logic [WIDTH-1:0] seedData
);
  scrStrobes_t strb;

  scrCtrl u_ctrl (
    .txStart(txStart), .txShortFmt(txShortFmt), .txEn(txEn), .rxEn(rxEn),
    .bypass(bypass), .longSeedWe(longSeedWe), .shortSeedWe(shortSeedWe),
    .strb(strb)
  );

  scrDatapath #(
    .WIDTH(WIDTH), .TAP_A(TAP_A), .TAP_B(TAP_B),
    .LONG_DEF(LONG_DEF), .SHORT_DEF(SHORT_DEF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .seedData(seedData),
    .txBit(txBit), .rxBit(rxBit), .txOut(txOut), .rxOut(rxOut)
  );
endmodule

// File: rtl/scrChecker.sv
module scrChecker #(
  parameter int               WIDTH     = 7,
  parameter int               TAP_A     = 4,
  parameter int               TAP_B     = 7,
  parameter logic [WIDTH-1:0] LONG_DEF  = 7'b1101100,
  parameter logic [WIDTH-1:0] SHORT_DEF = 7'b0011011
) (
  input logic             clk,
  input logic             rstN,
  input logic             bypass,
  input logic             txShortFmt,
  input logic             txStart,
  input logic             txEn,
  input logic             txBit,
  input logic             txOut,
  input logic             rxEn,
  input logic             rxBit,
  input logic             rxOut,
  input logic             longSeedWe,
  input logic             shortSeedWe,
  input logic [WIDTH-1:0] seedData
);
  logic [WIDTH-1:0] lShadow, sShadow, selShadow, txHist, txCur, rxHist;

  assign selShadow = txShortFmt ? sShadow : lShadow;
  assign txCur     = txStart ? selShadow : txHist;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lShadow <= LONG_DEF;
      sShadow <= SHORT_DEF;
      txHist  <= txShortFmt ? SHORT_DEF : LONG_DEF;
      rxHist  <= '0;
    end else begin
      if (longSeedWe)  lShadow <= seedData;
      if (shortSeedWe) sShadow <= seedData;
      txHist <= txEn ? {txCur[WIDTH-2:0], txOut} : txCur;
      if (rxEn) rxHist <= {rxHist[WIDTH-2:0], rxBit};
    end
  end

  p_tx_bypass_r5: assert property (@(posedge clk) disable iff (!rstN)
    bypass |-> (txOut == txBit));
  p_rx_bypass_r5: assert property (@(posedge clk) disable iff (!rstN)
    bypass |-> (rxOut == rxBit));
  p_tx_seq_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && !txStart && !bypass) |-> (txOut == (txBit ^ txHist[TAP_A-1] ^ txHist[TAP_B-1])));
  p_tx_seed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && txStart && !bypass) |-> (txOut == (txBit ^ selShadow[TAP_A-1] ^ selShadow[TAP_B-1])));
  p_rx_seq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxEn && !bypass) |-> (rxOut == (rxBit ^ rxHist[TAP_A-1] ^ rxHist[TAP_B-1])));
  p_lock_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && !txStart && !bypass && (txHist == '0) && !txBit) |-> !txOut);
endmodule

bind selfSyncScrambler scrChecker #(
  .WIDTH(WIDTH), .TAP_A(TAP_A), .TAP_B(TAP_B),
  .LONG_DEF(LONG_DEF), .SHORT_DEF(SHORT_DEF)
) u_scrChecker (
  .clk(clk), .rstN(rstN), .bypass(bypass), .txShortFmt(txShortFmt),
  .txStart(txStart), .txEn(txEn), .txBit(txBit), .txOut(txOut),
  .rxEn(rxEn), .rxBit(rxBit), .rxOut(rxOut),
  .longSeedWe(longSeedWe), .shortSeedWe(shortSeedWe), .seedData(seedData)
);

// File: tb/test_selfSyncScrambler.sv
module test_selfSyncScrambler;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bypass = 1'b0, txShortFmt = 1'b0, txStart = 1'b0, txEn = 1'b0, txBit = 1'b0;
  logic rxEn = 1'b0, rxBit = 1'b0, longSeedWe = 1'b0, shortSeedWe = 1'b0;
  logic [6:0] seedData = '0;
  logic txOut, rxOut;

  int nChecks = 0;
  int nFail = 0;
  logic [6:0] mTx, mRx, mLong, mShort;
  int loopCnt = 0;

  always #5 clk = ~clk;

  selfSyncScrambler i_selfSyncScrambler (
    .clk(clk), .rstN(rstN), .bypass(bypass), .txShortFmt(txShortFmt),
    .txStart(txStart), .txEn(txEn), .txBit(txBit), .txOut(txOut),
    .rxEn(rxEn), .rxBit(rxBit), .rxOut(rxOut),
    .longSeedWe(longSeedWe), .shortSeedWe(shortSeedWe), .seedData(seedData)
  );

  function automatic logic scrBit(input logic [6:0] st, input logic b);
    return b ^ st[3] ^ st[6];
  endfunction

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic fmt);
    @(negedge clk);
    rstN = 1'b0; txShortFmt = fmt; txEn = 0; rxEn = 0; txStart = 0;
    bypass = 0; longSeedWe = 0; shortSeedWe = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mLong = 7'b1101100; mShort = 7'b0011011;
    mTx = fmt ? mShort : mLong; mRx = '0;
  endtask

  // One bit cycle. loop=1 feeds the predicted transmit output into rxBit.
  task automatic cyc(input logic st, input logic fm, input logic te, input logic tb,
                     input logic re, input logic rb, input logic by,
                     input logic wl, input logic ws, input logic [6:0] sd,
                     input bit loop, input string tag);
    logic [6:0] cur;
    logic expT, expR, rbU;
    @(negedge clk);
    cur  = st ? (fm ? mShort : mLong) : mTx;
    expT = by ? tb : scrBit(cur, tb);
    rbU  = loop ? expT : rb;
    expR = by ? rbU : scrBit(mRx, rbU);
    txStart = st; txShortFmt = fm; txEn = te; txBit = tb;
    rxEn = re; rxBit = rbU; bypass = by;
    longSeedWe = wl; shortSeedWe = ws; seedData = sd;
    #1;
    if (te) check(txOut === expT, {tag, " tx"}, txOut, expT);
    if (re) check(rxOut === expR, {tag, " rx"}, rxOut, expR);
    if (loop && re && te && !by) begin
      if (loopCnt >= 7) check(rxOut === tb, "R7 recovered data", rxOut, tb);
      loopCnt++;
    end
    @(posedge clk);
    mTx = te ? {cur[5:0], expT} : cur;
    if (re) mRx = {mRx[5:0], rbU};
    if (wl) mLong = sd;
    if (ws) mShort = sd;
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd2024);

    // R1: reset state, long format, zero input exposes the default seed
    doReset(1'b0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0, 1, 1'b1, 0, 0, 0, '0, 0, "R1");

    // R1: reset with short format
    doReset(1'b1);
    for (int i = 0; i < 10; i++) cyc(0, 1, 1, 0, 0, 0, 0, 0, 0, '0, 0, "R1 short");

    // R2/R3: random frames, both formats
    for (int f = 0; f < 6; f++) begin
      logic fm;
      fm = f[0];
      cyc(1, fm, 1, 1'($urandom), 0, 0, 0, 0, 0, '0, 0, "R3 start");
      for (int i = 0; i < 40; i++)
        cyc(0, fm, 1, 1'($urandom), 0, 0, 0, 0, 0, '0, 0, "R2");
    end

    // R3: start without a bit, then data
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, '0, 0, "R3");
    for (int i = 0; i < 8; i++) cyc(0, 1, 1, 0, 0, 0, 0, 0, 0, '0, 0, "R3 seed only");

    // R4: seed writes and independence
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 7'h55, 0, "R4");
    cyc(1, 1, 1, 0, 0, 0, 0, 0, 0, '0, 0, "R4 short untouched");
    for (int i = 0; i < 7; i++) cyc(0, 1, 1, 0, 0, 0, 0, 0, 0, '0, 0, "R4");
    cyc(1, 0, 1, 0, 0, 0, 0, 0, 1, 7'h2a, 0, "R4 long written");
    for (int i = 0; i < 7; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, '0, 0, "R4");
    cyc(1, 1, 1, 1, 0, 0, 0, 0, 0, '0, 0, "R4 short written");
    for (int r = 0; r < 5; r++) begin
      logic [6:0] sd;
      sd = 7'($urandom);
      cyc(0, 0, 0, 0, 0, 0, 0, r[0], !r[0], sd, 0, "R4 write");
      cyc(1, !r[0], 1, 1'($urandom), 0, 0, 0, 0, 0, '0, 0, "R4 use");
      for (int i = 0; i < 10; i++) cyc(0, 0, 1, 1'($urandom), 0, 0, 0, 0, 0, '0, 0, "R4");
    end

    // R6: idle gaps with toggling data
    for (int i = 0; i < 60; i++) begin
      logic e;
      e = ($urandom % 3) == 0;
      cyc(0, 0, e, 1'($urandom), e, 1'($urandom), 0, 0, 0, '0, 0, "R6");
    end

    // R5: bypass on both paths, then resume
    for (int i = 0; i < 30; i++)
      cyc(0, 0, 1, 1'($urandom), 1, 1'($urandom), 1, 0, 0, '0, 0, "R5");
    for (int i = 0; i < 20; i++)
      cyc(0, 0, 1, 1'($urandom), 1, 1'($urandom), 0, 0, 0, '0, 0, "R5 resume");

    // R7: loopback from arbitrary receive state
    loopCnt = 0;
    cyc(1, 1, 1, 1'($urandom), 1, 0, 0, 0, 0, '0, 1, "R7");
    for (int i = 0; i < 60; i++)
      cyc(0, 1, 1, 1'($urandom), 1, 0, 0, 0, 0, '0, 1, "R7");

    // R8: lock-up on zeros, then a break
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 7'h00, 0, "R8");
    cyc(1, 0, 1, 0, 0, 0, 0, 0, 0, '0, 0, "R8 zeros");
    for (int i = 0; i < 16; i++) begin
      cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, '0, 0, "R8 zeros");
      check(txOut === 1'b0, "R8 stuck zero", txOut, 1'b0);
    end
    begin
      int ones;
      ones = 0;
      cyc(0, 0, 1, 1, 0, 0, 0, 0, 0, '0, 0, "R8 break");
      for (int i = 0; i < 7; i++) begin
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, '0, 0, "R8 after break");
        if (txOut === 1'b1) ones++;
      end
      check(ones > 0, "R8 restart", ones > 0, 1'b1);
    end
    // R8: lock-up on ones
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 7'h7f, 0, "R8");
    cyc(1, 0, 1, 1, 0, 0, 0, 0, 0, '0, 0, "R8 ones");
    for (int i = 0; i < 12; i++) begin
      cyc(0, 0, 1, 1, 0, 0, 0, 0, 0, '0, 0, "R8 ones");
      check(txOut === 1'b1, "R8 stuck one", txOut, 1'b1);
    end
    begin
      int zeros;
      zeros = 0;
      cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, '0, 0, "R8 break");
      for (int i = 0; i < 7; i++) begin
        cyc(0, 0, 1, 1, 0, 0, 0, 0, 0, '0, 0, "R8 after break");
        if (txOut === 1'b0) zeros++;
      end
      check(zeros > 0, "R8 restart ones", zeros > 0, 1'b1);
    end

    @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule